// File: doc/BRIEF.md
# Guarded Block-Write Sequencer for Non-Volatile Data Memory

This block sits between a processor register bus and a word-wide non-volatile data array. Software stages one block of sixteen words in a write latch buffer through table writes, then sets up the control register. It writes a two-part unlock key and finally sets the start bit. The sequencer copies the staged block into the array only when every guard is satisfied. Otherwise it flags an error and leaves the array untouched. A fixed programming interval is modelled by a busy period. During that period the bus is back-pressured.

The bus is a single valid/ready channel carrying both writes and reads. An access is taken on a rising clock edge where `bus_valid` and `bus_ready` are both high. `bus_ready` is low for the whole busy period. The master must hold the address, data and control stable until the access is taken. Read data is combinational from the address presented and is valid in the cycle the access is taken. With `bus_tbl` high the access targets the latch buffer on writes and the array on reads. With `bus_tbl` low, `bus_addr[1:0]` selects a register: 0 is control, 1 is the key, and 2 is the captured address (read only). Cycles with `bus_valid` low are not accesses.

Top module: `nvm_block_writer`

## Requirements
- R1: A table write stores its data in latch slot `bus_addr[3:0]`, so slot indices wrap modulo 16. Register 2 reads back the address of the most recent table write, zero-extended.
- R2: A committed block is written to the sixteen array words starting at the captured address with its low four bits cleared. Word k of the block receives latch slot k.
- R3: A start is accepted only if the two accesses just before it were a key write of 0x0055 and then a key write of 0x00AA. A wrong key value, the keys in the wrong order, or any other access in between causes the start to be rejected.
- R4: Write enable (control bit 14) is 0 after reset. A start with write enable at 0 is rejected.
- R5: For PWRT_CYCLES cycles after reset a start request is ignored. Busy does not rise, no error is flagged, and the array is unchanged.
- R6: An accepted start holds `busy` high for exactly PROG_CYCLES cycles, and the start bit (control bit 15) mirrors busy. When the commit happens, busy falls and `done` (control bit 12) rises. Write enable keeps its value.
- R7: `bus_ready` is low while busy. An access presented during that time is held, and it is taken in the first cycle after busy falls.
- R8: A rejected start sets the error flag (control bit 13) and leaves the array unchanged. Besides R3 and R4, a start is also rejected when the operation field (control bits 3:0) is not 0xA.
- R9: A start is rejected unless all sixteen latch slots have been written since the last commit. A commit empties the fill record.
- R10: A control write with bit 15 at 0 loads write enable and the operation field. It clears error or done where the written bit is 0 and leaves them unchanged where it is 1. A control write with bit 15 at 1 changes no other field.
- R11: After reset every array word reads 0xFFFF, the control register reads 0x0000, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access can be taken; low while busy |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_tbl | input | 1 | 1 targets latches/array, 0 targets registers |
| bus_addr | input | AW | Word address, or register select in bits 1:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the presented address |
| busy | output | 1 | Programming interval in progress |
| done | output | 1 | Last accepted block write has completed |

## Verification
Two things can meet in one cycle: the end of a commit, which empties the latch fill record, and a table write held back by the busy period, which is taken in the very next cycle. The bench provokes this by presenting a table write right after an accepted start. It then judges three results: the committed block must not contain the held word, the captured address must show the held write, and a later start with one slot still missing must be rejected because the held write alone filled just one slot of the new block.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  localparam int DW = 16;
  localparam logic [DW-1:0] KEY_FIRST  = 16'h0055;
  localparam logic [DW-1:0] KEY_SECOND = 16'h00AA;
  localparam logic [3:0]    OP_BLOCK   = 4'hA;
  localparam int B_START = 15;
  localparam int B_WREN  = 14;
  localparam int B_ERR   = 13;
  localparam int B_DONE  = 12;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_KEY  = 2'd1,
    REG_ADDR = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
  import nvm_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          armed
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (acc) begin
      case (st_q)
        UL_IDLE: st_d = (key_wr && wdata == KEY_FIRST) ? UL_HALF : UL_IDLE;
        UL_HALF: st_d = (key_wr && wdata == KEY_SECOND) ? UL_ARMED : UL_IDLE;
        default: st_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_latch_buf.sv
module nvm_latch_buf
  import nvm_seq_pkg::*;
#(
  parameter int LATCHES = 16,
  parameter int AW      = 6,
  localparam int LW     = $clog2(LATCHES)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wdata,
  input  logic                  clear,
  output logic [LATCHES*DW-1:0] latch_flat,
  output logic                  full,
  output logic [AW-1:0]         cap_addr
);
  logic [LW-1:0]      wr_idx;
  logic [LATCHES-1:0] loaded_q;

  assign wr_idx = wr_addr[LW-1:0];

  for (genvar g = 0; g < LATCHES; g++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (wr_en && wr_idx == LW'(g))     q <= wdata;
    end
    assign latch_flat[g*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      cap_addr <= '0;
    end else if (clear) begin
      loaded_q <= '0;
    end else if (wr_en) begin
      loaded_q[wr_idx] <= 1'b1;
      cap_addr         <= wr_addr;
    end
  end

  assign full = &loaded_q;
endmodule

// File: rtl/nvm_array_model.sv
module nvm_array_model
  import nvm_seq_pkg::*;
#(
  parameter int            DEPTH   = 64,
  parameter int            LATCHES = 16,
  parameter logic [DW-1:0] ERASED  = 16'hFFFF,
  localparam int           AW      = $clog2(DEPTH)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [AW-1:0]         base,
  input  logic [LATCHES*DW-1:0] latch_flat,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int j = 0; j < LATCHES; j++)
        mem[base + AW'(j)] <= latch_flat[j*DW +: DW];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_block_writer.sv
module nvm_block_writer
  import nvm_seq_pkg::*;
#(
  parameter int  DEPTH       = 64,
  parameter int  LATCHES     = 16,
  parameter int  PROG_CYCLES = 20,
  parameter int  PWRT_CYCLES = 64,
  localparam int AW          = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic          bus_tbl,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done
);
  localparam int LW  = $clog2(LATCHES);
  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam int TCW = $clog2(PWRT_CYCLES + 1);

  logic                  busy_q, wren_q, err_q, done_q;
  logic [3:0]            op_q;
  logic [PCW-1:0]        prog_cnt;
  logic [TCW-1:0]        pwrt_cnt;
  logic                  armed, full;
  logic [AW-1:0]         cap_addr, base;
  logic [LATCHES*DW-1:0] latch_flat;
  logic [DW-1:0]         arr_rd;
  reg_sel_e              sel;
  logic acc, tbl_wr, key_wr, ctrl_wr, ctrl_plain, start_req;
  logic pwr_ok, start_ok, accept, reject, finish;

  assign bus_ready  = !busy_q;
  assign acc        = bus_valid && bus_ready;
  assign sel        = reg_sel_e'(bus_addr[1:0]);
  assign tbl_wr     = acc && bus_write && bus_tbl;
  assign key_wr     = acc && bus_write && !bus_tbl && (sel == REG_KEY);
  assign ctrl_wr    = acc && bus_write && !bus_tbl && (sel == REG_CTRL);
  assign start_req  = ctrl_wr && bus_wdata[B_START];
  assign ctrl_plain = ctrl_wr && !bus_wdata[B_START];
  assign pwr_ok     = (pwrt_cnt == '0);
  assign start_ok   = armed && wren_q && (op_q == OP_BLOCK) && full;
  assign accept     = start_req && pwr_ok && start_ok;
  assign reject     = start_req && pwr_ok && !start_ok;
  assign finish     = busy_q && (prog_cnt == '0);
  assign base       = {cap_addr[AW-1:LW], {LW{1'b0}}};

  nvm_unlock_fsm u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .key_wr (key_wr),
    .wdata  (bus_wdata),
    .armed  (armed)
  );

  nvm_latch_buf #(.LATCHES(LATCHES), .AW(AW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_wr),
    .wr_addr    (bus_addr),
    .wdata      (bus_wdata),
    .clear      (finish),
    .latch_flat (latch_flat),
    .full       (full),
    .cap_addr   (cap_addr)
  );

  nvm_array_model #(.DEPTH(DEPTH), .LATCHES(LATCHES)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (finish),
    .base       (base),
    .latch_flat (latch_flat),
    .rd_addr    (bus_addr),
    .rd_data    (arr_rd)
  );

  // power-up hold-off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwrt_cnt <= TCW'(PWRT_CYCLES);
    else if (!pwr_ok) pwrt_cnt <= pwrt_cnt - 1'b1;
  end

  // programming interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      prog_cnt <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      prog_cnt <= PCW'(PROG_CYCLES - 1);
    end else if (finish) begin
      busy_q   <= 1'b0;
    end else if (busy_q) begin
      prog_cnt <= prog_cnt - 1'b1;
    end
  end

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
    end else begin
      if (ctrl_plain) begin
        wren_q <= bus_wdata[B_WREN];
        op_q   <= bus_wdata[3:0];
        err_q  <= err_q & bus_wdata[B_ERR];
        done_q <= done_q & bus_wdata[B_DONE];
      end
      if (reject) err_q  <= 1'b1;
      if (accept) done_q <= 1'b0;
      if (finish) done_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_tbl) begin
      bus_rdata = arr_rd;
    end else begin
      case (sel)
        REG_CTRL: bus_rdata = {busy_q, wren_q, err_q, done_q, 8'h00, op_q};
        REG_ADDR: bus_rdata = {{(DW-AW){1'b0}}, cap_addr};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/nvm_block_writer_chk.sv
module nvm_block_writer_chk #(
  parameter int PROG_CYCLES = 20
)(
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic armed,
  input logic pwr_ok,
  input logic wren
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 32'(PROG_CYCLES));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  armed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  // R5
  pwrt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_ok));

  // R4
  wren_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wren));

  // R7
  held_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wren));
endmodule

bind nvm_block_writer nvm_block_writer_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy_q),
  .done   (done_q),
  .armed  (armed),
  .pwr_ok (pwr_ok),
  .wren   (wren_q)
);

// File: tb/nvm_block_writer_test.sv
module nvm_block_writer_test;
  localparam int PROG = 12;
  localparam int PWRT = 60;
  localparam int AW   = 6;

  typedef struct packed {
    logic [7:0]  base;
    logic [15:0] seed;
    logic [15:0] k1;
    logic [15:0] k2;
    logic [15:0] ctrl;
    logic        ok;
  } vec_t;

  // R2 R3 R4 R8 R6 R10
  localparam vec_t VECS [6] = '{
    '{8'h00, 16'h1000, 16'h0055, 16'h00AA, 16'h400A, 1'b1},
    '{8'h10, 16'h2000, 16'h0055, 16'h00AB, 16'h400A, 1'b0},
    '{8'h20, 16'h3000, 16'h00AA, 16'h0055, 16'h400A, 1'b0},
    '{8'h20, 16'h4000, 16'h0055, 16'h00AA, 16'h000A, 1'b0},
    '{8'h30, 16'h5000, 16'h0055, 16'h00AA, 16'h4003, 1'b0},
    '{8'h10, 16'h6000, 16'h0055, 16'h00AA, 16'h400A, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_tbl = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_ready, busy, done;
  logic [15:0] bus_rdata;
  int checks = 0, errors = 0;
  logic [15:0] model [64];
  logic [15:0] rd;
  int nbusy;

  always #10 clk = ~clk;

  nvm_block_writer #(.DEPTH(64), .LATCHES(16), .PROG_CYCLES(PROG), .PWRT_CYCLES(PWRT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_tbl(bus_tbl), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic t, input logic [7:0] a,
                        input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_tbl = t; bus_addr = a[AW-1:0]; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    #1 r = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic fill(input logic [7:0] base, input logic [15:0] seed, input int n);
    logic [15:0] junk;
    for (int i = 0; i < n; i++) bus_op(1'b1, 1'b1, base + 8'(i), seed + 16'(i), junk);
  endtask

  task automatic check_blk(input string req, input logic [7:0] base);
    int bad = 0;
    logic [15:0] v, first_act, first_exp;
    first_act = '0; first_exp = '0;
    for (int i = 0; i < 16; i++) begin
      bus_op(1'b0, 1'b1, base + 8'(i), 16'h0, v);
      if (v !== model[base + 8'(i)]) begin
        if (bad == 0) begin first_act = v; first_exp = model[base + 8'(i)]; end
        bad++;
      end
    end
    check(req, first_act, first_exp);
  endtask

  task automatic count_busy();
    nbusy = 0;
    @(negedge clk);
    while (busy) begin
      if (bus_ready) check("R7 ready low while busy", 16'(bus_ready), 16'h0);
      nbusy++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 busy after reset", 16'(busy), 16'h0);
    check("R11 done after reset", 16'(done), 16'h0);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R11 R4 ctrl after reset", rd, 16'h0000);
    bus_op(1'b0, 1'b1, 8'h07, 16'h0, rd);
    check("R11 array erased", rd, 16'hFFFF);

    // R5 full sequence inside power-up window is ignored
    fill(8'h00, 16'hAAA0, 16);
    bus_op(1'b1, 1'b0, 8'h00, 16'h400A, rd);
    bus_op(1'b1, 1'b0, 8'h01, 16'h0055, rd);
    bus_op(1'b1, 1'b0, 8'h01, 16'h00AA, rd);
    bus_op(1'b1, 1'b0, 8'h00, 16'h8000, rd);
    @(negedge clk);
    check("R5 no busy in hold-off", 16'(busy), 16'h0);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R5 no error in hold-off", rd, 16'h400A);
    repeat (PWRT) @(negedge clk);
    check_blk("R5 array unchanged", 8'h00);

    // table of scenarios
    foreach (VECS[k]) begin
      fill(VECS[k].base, VECS[k].seed, 16);
      bus_op(1'b1, 1'b0, 8'h00, VECS[k].ctrl, rd);
      bus_op(1'b1, 1'b0, 8'h01, VECS[k].k1, rd);
      bus_op(1'b1, 1'b0, 8'h01, VECS[k].k2, rd);
      bus_op(1'b1, 1'b0, 8'h00, 16'h8000, rd);
      count_busy();
      check($sformatf("R6 busy cycles vec%0d", k), 16'(nbusy), VECS[k].ok ? 16'(PROG) : 16'h0);
      if (VECS[k].ok)
        for (int i = 0; i < 16; i++) model[VECS[k].base + 8'(i)] = VECS[k].seed + 16'(i);
      bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
      check($sformatf("R8 R10 ctrl vec%0d", k), rd,
            (VECS[k].ctrl & 16'h400F) | (VECS[k].ok ? 16'h1000 : 16'h2000));
      check_blk($sformatf("R2 R8 block vec%0d", k), VECS[k].base);
    end

    // R3 intervening access between key and start
    bus_op(1'b1, 1'b0, 8'h00, 16'h400A, rd);
    fill(8'h00, 16'h7000, 16);
    bus_op(1'b1, 1'b0, 8'h01, 16'h0055, rd);
    bus_op(1'b1, 1'b0, 8'h01, 16'h00AA, rd);
    bus_op(1'b0, 1'b0, 8'h02, 16'h0, rd);
    bus_op(1'b1, 1'b0, 8'h00, 16'h8000, rd);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R3 intervening read rejects", rd, 16'h600A);
    check_blk("R3 array unchanged", 8'h00);

    // R1 wrap and capture, R2 base, R7 held write concurrent with commit
    bus_op(1'b1, 1'b0, 8'h00, 16'h400A, rd);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] s;
      s = 4'(i + 5);
      bus_op(1'b1, 1'b1, 8'h30 + 8'(s), 16'h8000 + 16'(s), rd);
    end
    bus_op(1'b0, 1'b0, 8'h02, 16'h0, rd);
    check("R1 captured address", rd, 16'h0034);
    bus_op(1'b1, 1'b1, 8'h14, 16'h9999, rd);
    bus_op(1'b1, 1'b0, 8'h01, 16'h0055, rd);
    bus_op(1'b1, 1'b0, 8'h01, 16'h00AA, rd);
    bus_op(1'b1, 1'b0, 8'h00, 16'h8000, rd);
    fork
      count_busy();
      bus_op(1'b1, 1'b1, 8'h2F, 16'h2F2F, rd);
    join
    check("R6 busy cycles wrap", 16'(nbusy), 16'(PROG));
    for (int i = 0; i < 16; i++) model[8'h10 + 8'(i)] = (i == 4) ? 16'h9999 : 16'h8000 + 16'(i);
    check_blk("R1 R2 wrapped block at base", 8'h10);
    bus_op(1'b0, 1'b0, 8'h02, 16'h0, rd);
    check("R7 held write taken after busy", rd, 16'h002F);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R6 wren kept after commit", rd, 16'h500A);
    check("R6 done port", 16'(done), 16'h1);

    // R9 incomplete fill (held write gave slot 15 only; slot 14 missing)
    fill(8'h20, 16'hB000, 14);
    bus_op(1'b1, 1'b0, 8'h01, 16'h0055, rd);
    bus_op(1'b1, 1'b0, 8'h01, 16'h00AA, rd);
    bus_op(1'b1, 1'b0, 8'h00, 16'h8000, rd);
    @(negedge clk);
    check("R9 no busy on partial fill", 16'(busy), 16'h0);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R9 error on partial fill", rd, 16'h700A);
    check_blk("R9 array unchanged", 8'h20);

    // R10 flag write rules
    bus_op(1'b1, 1'b0, 8'h00, 16'h700A, rd);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R10 writing ones keeps flags", rd, 16'h700A);
    bus_op(1'b1, 1'b0, 8'h00, 16'h0003, rd);
    bus_op(1'b0, 1'b0, 8'h00, 16'h0, rd);
    check("R10 writing zeros clears flags", rd, 16'h0003);
    check("R10 done port cleared", 16'(done), 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule